// File: doc/BRIEF.md
# Warp-Granular Request Injection Throttle

This block sits between a core's load/store path and its on-chip network port. It takes one warp at a time, where a warp is a bundle of one to `MAX_REQ` memory requests. Each request names a target memory controller, a bank within it and an address. The block decides whether the whole warp may enter the network. Each request is then sent out in order, one per handshake.

Admission is all or nothing. Every controller/bank pair that the warp touches must have no request from this core still in flight. The core's total count of outstanding requests must also be strictly below a threshold supplied on an input. If the warp fails either test, none of it is sent and the test is repeated on every later cycle. Completion responses come back tagged with their controller and bank, and each one releases the pair counter and the total count.

Top module: `warp_inject_throttle`

## Requirements
- R1: A synchronous active-high reset empties the warp buffer and clears every pair counter and the outstanding count. After reset `warpReady` is 1 and `reqValid` is 0, and a warp to any pair is admitted at once.
- R2: A warp is captured on a clock edge where `warpValid` and `warpReady` are both 1. `warpReady` is 1 only while the buffer is empty. It stays 0 from the capture edge until the edge on which the warp's final request completes its output handshake, and it reads 1 in the cycle after that edge.
- R3: A buffered warp is admitted only if the in-flight counter of every pair it targets is zero. The pair index is `mc*NUM_BANK + bank`. A nonzero counter on a pair that the warp does not target does not block it.
- R4: A buffered warp is admitted only if the outstanding count is strictly less than `thresh`. With `thresh` equal to the count, or with `thresh` = 0, the warp waits.
- R5: A warp that is not admitted drives no request (`reqValid` = 0). It is evaluated again every cycle and is admitted in the first cycle in which both conditions hold.
- R6: The admission test is combinational over the registered buffer. A warp that passes drives `reqValid` = 1 in the first cycle after its capture edge.
- R7: Admitted requests leave in slot order 0 to `warpLast`. The slot is given on `warpMc[i*MC_W +: MC_W]`, `warpBank[i*BANK_W +: BANK_W]` and `warpAddr[i*ADDR_W +: ADDR_W]`, and the warp holds `warpLast+1` requests. One request is sent per cycle in which `reqValid` and `reqReady` are both 1. While `reqReady` is 0, the request on the outputs is held unchanged.
- R8: On admission, each pair counter rises by the number of the warp's requests that target it. The outstanding count rises by `warpLast+1`.
- R9: Each cycle with `rspValid` = 1 lowers the counter of the pair `rspMc`/`rspBank` by one and lowers the outstanding count by one. When an admission and a completion fall in the same cycle, both changes take effect.
- R10: Counters saturate and never wrap. A completion aimed at a counter that is already zero leaves it at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thresh | input | OUT_W | Outstanding-count limit; admission needs count < thresh |
| warpValid | input | 1 | Warp offered |
| warpReady | output | 1 | Warp buffer is empty and can take a warp |
| warpLast | input | IDX_W | Index of the warp's last request (request count minus one) |
| warpMc | input | MAX_REQ*MC_W | Controller index of each slot |
| warpBank | input | MAX_REQ*BANK_W | Bank index of each slot |
| warpAddr | input | MAX_REQ*ADDR_W | Address of each slot |
| reqValid | output | 1 | Request on the output is valid |
| reqReady | input | 1 | Network accepts the request |
| reqMc | output | MC_W | Controller index of the current request |
| reqBank | output | BANK_W | Bank index of the current request |
| reqAddr | output | ADDR_W | Address of the current request |
| rspValid | input | 1 | Completion response this cycle |
| rspMc | input | MC_W | Controller index of the completed request |
| rspBank | input | BANK_W | Bank index of the completed request |

## Verification
The assertions check every cycle that a capture closes the warp input and that a stalled request keeps its slot. They also check that an admission never happens at or above the threshold or with a busy target pair, and that the outstanding count follows the increment, release and floor rules. Some behaviour can only be shown by the bench's scenarios, because it spans many cycles of history. These are the all-or-nothing throttle against a pair still in flight and re-admission on the cycle after the blocking completion. So are the shared-cycle admit and completion, the repeated-pair warp that needs two releases, and the clearing of stale counters by reset.

// File: rtl/warp_throttle_pkg.sv
package warp_throttle_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic load;   // capture the offered warp into the buffer
    logic admit;  // buffered warp admitted this cycle
  } thrStrobe_t;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SEND  = 2'd2
  } thrState_t;

endpackage

// File: rtl/warp_throttle_ctl.sv
module warp_throttle_ctl
  import warp_throttle_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             warpValid,
  output logic             warpReady,
  input  logic             reqReady,
  output logic             reqValid,
  input  logic             admitOk,
  input  logic [IDX_W-1:0] bufLast,
  output logic [IDX_W-1:0] sendIdx,
  output thrStrobe_t       strobe
);

  thrState_t        state;
  logic [IDX_W-1:0] idx;
  logic             active;
  logic             advance;
  logic             drain;

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_EMPTY) && warpValid;
    strobe.admit = (state == ST_HOLD) && admitOk;
    active       = strobe.admit || (state == ST_SEND);
    advance      = active && reqReady;
    drain        = advance && (idx == bufLast);
  end

  assign warpReady = (state == ST_EMPTY);
  assign reqValid  = active;
  assign sendIdx   = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_EMPTY;
      idx   <= '0;
    end else begin
      case (state)
        ST_EMPTY: if (strobe.load) state <= ST_HOLD;
        ST_HOLD:  if (strobe.admit) state <= drain ? ST_EMPTY : ST_SEND;
        ST_SEND:  if (drain) state <= ST_EMPTY;
        default:  state <= ST_EMPTY;
      endcase
      if (drain)        idx <= '0;
      else if (advance) idx <= idx + IDX_W'(1);
    end
  end

  // R2: a captured warp closes the input on the next cycle
  assert_accept_closes_R2: assert property (@(posedge clk) disable iff (rst)
    (warpValid && warpReady) |=> !warpReady);

  // R7: a stalled request stays offered in the same slot
  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqReady) |=> (reqValid && $stable(sendIdx)));

endmodule

// File: rtl/warp_throttle_dp.sv
module warp_throttle_dp
  import warp_throttle_pkg::*;
#(
  parameter int NUM_MC     = 2,
  parameter int NUM_BANK   = 4,
  parameter int MAX_REQ    = 4,
  parameter int MC_W       = 1,
  parameter int BANK_W     = 2,
  parameter int IDX_W      = 2,
  parameter int ADDR_W     = 16,
  parameter int PAIR_CNT_W = 4,
  parameter int OUT_W      = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  thrStrobe_t                strobe,
  input  logic [OUT_W-1:0]          thresh,
  input  logic [IDX_W-1:0]          warpLast,
  input  logic [MAX_REQ*MC_W-1:0]   warpMc,
  input  logic [MAX_REQ*BANK_W-1:0] warpBank,
  input  logic [MAX_REQ*ADDR_W-1:0] warpAddr,
  input  logic                      rspValid,
  input  logic [MC_W-1:0]           rspMc,
  input  logic [BANK_W-1:0]         rspBank,
  input  logic [IDX_W-1:0]          sendIdx,
  output logic                      admitOk,
  output logic [IDX_W-1:0]          bufLast,
  output logic [MC_W-1:0]           reqMc,
  output logic [BANK_W-1:0]         reqBank,
  output logic [ADDR_W-1:0]         reqAddr
);

  localparam int NUM_PAIR  = NUM_MC * NUM_BANK;
  localparam int PAIR_W    = (NUM_PAIR > 1) ? $clog2(NUM_PAIR) : 1;
  localparam int INC_W     = $clog2(MAX_REQ + 1);
  localparam int SUM_W     = ((PAIR_CNT_W > INC_W) ? PAIR_CNT_W : INC_W) + 1;
  localparam int PAIR_MAX  = (1 << PAIR_CNT_W) - 1;
  localparam int OUT_SUM_W = ((OUT_W > IDX_W + 1) ? OUT_W : IDX_W + 1) + 1;
  localparam int OUT_MAX   = (1 << OUT_W) - 1;

  function automatic logic [PAIR_W-1:0] pairOf(input logic [MC_W-1:0] m,
                                               input logic [BANK_W-1:0] b);
    return PAIR_W'(int'(m) * NUM_BANK + int'(b));
  endfunction

  // Warp buffer
  logic [MC_W-1:0]   bufMc   [MAX_REQ];
  logic [BANK_W-1:0] bufBank [MAX_REQ];
  logic [ADDR_W-1:0] bufAddr [MAX_REQ];
  logic [IDX_W-1:0]  bufLastQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      bufLastQ <= '0;
      for (int i = 0; i < MAX_REQ; i++) begin
        bufMc[i]   <= '0;
        bufBank[i] <= '0;
        bufAddr[i] <= '0;
      end
    end else if (strobe.load) begin
      bufLastQ <= warpLast;
      for (int i = 0; i < MAX_REQ; i++) begin
        bufMc[i]   <= warpMc[i*MC_W +: MC_W];
        bufBank[i] <= warpBank[i*BANK_W +: BANK_W];
        bufAddr[i] <= warpAddr[i*ADDR_W +: ADDR_W];
      end
    end
  end

  assign bufLast = bufLastQ;

  // Per-slot pair index and occupancy
  logic [PAIR_W-1:0]  slotPair [MAX_REQ];
  logic [MAX_REQ-1:0] slotUsed;

  for (genvar i = 0; i < MAX_REQ; i++) begin : g_slot
    assign slotPair[i] = pairOf(bufMc[i], bufBank[i]);
    assign slotUsed[i] = (IDX_W'(i) <= bufLastQ);
  end

  // Counters
  logic [PAIR_CNT_W-1:0] pairCnt  [NUM_PAIR];
  logic [PAIR_CNT_W-1:0] pairNext [NUM_PAIR];
  logic [SUM_W-1:0]      pairSum  [NUM_PAIR];
  logic [OUT_W-1:0]      outCnt;
  logic [OUT_W-1:0]      outNext;
  logic [OUT_SUM_W-1:0]  outSum;
  logic [OUT_SUM_W-1:0]  warpLen;
  logic [PAIR_W-1:0]     rspPair;
  logic                  pairsClear;

  assign rspPair = pairOf(rspMc, rspBank);
  assign warpLen = OUT_SUM_W'(bufLastQ) + OUT_SUM_W'(1);

  // Admission test over the registered buffer
  always_comb begin
    pairsClear = 1'b1;
    for (int i = 0; i < MAX_REQ; i++) begin
      if (slotUsed[i] && (pairCnt[slotPair[i]] != '0)) pairsClear = 1'b0;
    end
  end

  assign admitOk = pairsClear && (outCnt < thresh);

  always_comb begin
    for (int p = 0; p < NUM_PAIR; p++) begin
      pairSum[p] = SUM_W'(pairCnt[p]);
      if (strobe.admit) begin
        for (int i = 0; i < MAX_REQ; i++) begin
          if (slotUsed[i] && (slotPair[i] == PAIR_W'(p)))
            pairSum[p] = pairSum[p] + SUM_W'(1);
        end
      end
      if (rspValid && (rspPair == PAIR_W'(p)) && (pairSum[p] != '0))
        pairSum[p] = pairSum[p] - SUM_W'(1);
      pairNext[p] = (pairSum[p] > SUM_W'(PAIR_MAX)) ? PAIR_CNT_W'(PAIR_MAX)
                                                   : pairSum[p][PAIR_CNT_W-1:0];
    end
  end

  always_comb begin
    outSum = OUT_SUM_W'(outCnt);
    if (strobe.admit) outSum = outSum + warpLen;
    if (rspValid && (outSum != '0)) outSum = outSum - OUT_SUM_W'(1);
    outNext = (outSum > OUT_SUM_W'(OUT_MAX)) ? OUT_W'(OUT_MAX) : outSum[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outCnt <= '0;
      for (int p = 0; p < NUM_PAIR; p++) pairCnt[p] <= '0;
    end else begin
      outCnt <= outNext;
      for (int p = 0; p < NUM_PAIR; p++) pairCnt[p] <= pairNext[p];
    end
  end

  // Output selection
  assign reqMc   = bufMc[sendIdx];
  assign reqBank = bufBank[sendIdx];
  assign reqAddr = bufAddr[sendIdx];

  // R3: the control never admits while a targeted pair is busy
  assert_pairs_clear_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.admit |-> pairsClear);

  // R4: the control never admits at or above the limit
  assert_below_limit_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.admit |-> (outCnt < thresh));

  // R8: admission without a completion adds the warp length
  assert_count_up_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.admit && !rspValid &&
     ((OUT_SUM_W'(outCnt) + warpLen) <= OUT_SUM_W'(OUT_MAX)))
    |=> (OUT_SUM_W'(outCnt) == $past(OUT_SUM_W'(outCnt) + warpLen)));

  // R9: a completion alone releases one outstanding request
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !strobe.admit && (outCnt != '0))
    |=> (outCnt == $past(outCnt) - OUT_W'(1)));

  // R10: a completion at zero leaves the count at zero
  assert_floor_R10: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !strobe.admit && (outCnt == '0)) |=> (outCnt == '0));

endmodule

// File: rtl/warp_inject_throttle.sv
module warp_inject_throttle
  import warp_throttle_pkg::*;
#(
  parameter int NUM_MC     = 2,
  parameter int NUM_BANK   = 4,
  parameter int MAX_REQ    = 4,
  parameter int ADDR_W     = 16,
  parameter int PAIR_CNT_W = 4,
  parameter int OUT_W      = 6,
  localparam int MC_W      = (NUM_MC > 1) ? $clog2(NUM_MC) : 1,
  localparam int BANK_W    = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int IDX_W     = (MAX_REQ > 1) ? $clog2(MAX_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [OUT_W-1:0]          thresh,
  input  logic                      warpValid,
  output logic                      warpReady,
  input  logic [IDX_W-1:0]          warpLast,
  input  logic [MAX_REQ*MC_W-1:0]   warpMc,
  input  logic [MAX_REQ*BANK_W-1:0] warpBank,
  input  logic [MAX_REQ*ADDR_W-1:0] warpAddr,
  output logic                      reqValid,
  input  logic                      reqReady,
  output logic [MC_W-1:0]           reqMc,
  output logic [BANK_W-1:0]         reqBank,
  output logic [ADDR_W-1:0]         reqAddr,
  input  logic                      rspValid,
  input  logic [MC_W-1:0]           rspMc,
  input  logic [BANK_W-1:0]         rspBank
);

  thrStrobe_t       strobe;
  logic             admitOk;
  logic [IDX_W-1:0] bufLast;
  logic [IDX_W-1:0] sendIdx;

  warp_throttle_ctl #(
    .IDX_W (IDX_W)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .warpValid (warpValid),
    .warpReady (warpReady),
    .reqReady  (reqReady),
    .reqValid  (reqValid),
    .admitOk   (admitOk),
    .bufLast   (bufLast),
    .sendIdx   (sendIdx),
    .strobe    (strobe)
  );

  warp_throttle_dp #(
    .NUM_MC     (NUM_MC),
    .NUM_BANK   (NUM_BANK),
    .MAX_REQ    (MAX_REQ),
    .MC_W       (MC_W),
    .BANK_W     (BANK_W),
    .IDX_W      (IDX_W),
    .ADDR_W     (ADDR_W),
    .PAIR_CNT_W (PAIR_CNT_W),
    .OUT_W      (OUT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .thresh   (thresh),
    .warpLast (warpLast),
    .warpMc   (warpMc),
    .warpBank (warpBank),
    .warpAddr (warpAddr),
    .rspValid (rspValid),
    .rspMc    (rspMc),
    .rspBank  (rspBank),
    .sendIdx  (sendIdx),
    .admitOk  (admitOk),
    .bufLast  (bufLast),
    .reqMc    (reqMc),
    .reqBank  (reqBank),
    .reqAddr  (reqAddr)
  );

endmodule

// File: tb/sim_warp_inject_throttle.sv
`timescale 1ns/1ps
module sim_warp_inject_throttle;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  thresh = 6'd63;
  logic        warpValid = 1'b0;
  logic        warpReady;
  logic [1:0]  warpLast = '0;
  logic [3:0]  warpMc = '0;
  logic [7:0]  warpBank = '0;
  logic [63:0] warpAddr = '0;
  logic        reqValid;
  logic        reqReady = 1'b1;
  logic        reqMc;
  logic [1:0]  reqBank;
  logic [15:0] reqAddr;
  logic        rspValid = 1'b0;
  logic        rspMc = 1'b0;
  logic [1:0]  rspBank = '0;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  warp_inject_throttle u0 (
    .clk(clk), .rst(rst), .thresh(thresh),
    .warpValid(warpValid), .warpReady(warpReady), .warpLast(warpLast),
    .warpMc(warpMc), .warpBank(warpBank), .warpAddr(warpAddr),
    .reqValid(reqValid), .reqReady(reqReady), .reqMc(reqMc),
    .reqBank(reqBank), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspMc(rspMc), .rspBank(rspBank)
  );

  // {last, mc per slot, bank per slot, base address}; slot i address = base+i
  localparam logic [29:0] VEC [5] = '{
    {2'd0, 4'b0000, 8'h00, 16'h1000},
    {2'd3, 4'b1010, 8'h39, 16'h2000},
    {2'd1, 4'b0011, 8'h0A, 16'h3000},
    {2'd2, 4'b0101, 8'h0F, 16'h4000},
    {2'd3, 4'b0000, 8'hFF, 16'hABC0}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sendWarp(input logic [1:0] l, input logic [3:0] m,
                          input logic [7:0] b, input logic [15:0] base);
    warpValid = 1'b1;
    warpLast  = l;
    warpMc    = m;
    warpBank  = b;
    warpAddr  = {base + 16'd3, base + 16'd2, base + 16'd1, base};
    for (int g = 0; g < 50 && !warpReady; g++) tick();
    tick();
    warpValid = 1'b0;
  endtask

  task automatic collect(input logic [1:0] l, input logic [3:0] m,
                         input logic [7:0] b, input logic [15:0] base);
    for (int i = 0; i <= int'(l); i++) begin
      for (int g = 0; g < 50 && !reqValid; g++) tick();
      check("R7 request mc", reqMc, m[i]);
      check("R7 request bank", reqBank, b[2*i +: 2]);
      check("R7 request addr", reqAddr, base + 16'(i));
      tick();
    end
  endtask

  task automatic respond(input logic m, input logic [1:0] b);
    rspValid = 1'b1;
    rspMc    = m;
    rspBank  = b;
    tick();
    rspValid = 1'b0;
  endtask

  task automatic respondAll(input logic [1:0] l, input logic [3:0] m, input logic [7:0] b);
    for (int i = 0; i <= int'(l); i++) respond(m[i], b[2*i +: 2]);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finishRun();
    end
  end

  initial begin
    logic [1:0]  vl;
    logic [3:0]  vm;
    logic [7:0]  vb;
    logic [15:0] va;
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check("R1 warpReady after reset", warpReady, 1);
    check("R1 reqValid after reset", reqValid, 0);

    // Table of warps with all counters idle
    for (int k = 0; k < 5; k++) begin
      {vl, vm, vb, va} = VEC[k];
      sendWarp(vl, vm, vb, va);
      check("R6 immediate injection", reqValid, 1);
      check("R2 closed while sending", warpReady, 0);
      collect(vl, vm, vb, va);
      check("R2 ready after last handshake", warpReady, 1);
      check("R7 no request after drain", reqValid, 0);
      respondAll(vl, vm, vb);
    end

    // R3/R5: busy pair throttles whole warp until released
    sendWarp(0, 4'b0000, 8'h01, 16'h1100);
    collect(0, 4'b0000, 8'h01, 16'h1100);
    sendWarp(1, 4'b0001, 8'h06, 16'h1200);   // slot0 (1,2), slot1 (0,1)
    check("R3 busy pair blocks warp", reqValid, 0);
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R5 throttled warp sends nothing", reqValid, 0);
      check("R5 input closed while throttled", warpReady, 0);
    end
    respond(0, 2'd1);
    check("R5 admitted after release", reqValid, 1);
    collect(1, 4'b0001, 8'h06, 16'h1200);
    respond(1, 2'd2);
    respond(0, 2'd1);

    // R3: a busy pair outside the warp does not block it
    sendWarp(0, 4'b0000, 8'h01, 16'h1300);
    collect(0, 4'b0000, 8'h01, 16'h1300);
    sendWarp(0, 4'b0001, 8'h03, 16'h1400);
    check("R3 unrelated busy pair ignored", reqValid, 1);
    collect(0, 4'b0001, 8'h03, 16'h1400);
    respond(0, 2'd1);
    respond(1, 2'd3);

    // R8: a repeated pair needs one release per request
    sendWarp(1, 4'b0011, 8'h0A, 16'h6000);
    collect(1, 4'b0011, 8'h0A, 16'h6000);
    respond(1, 2'd2);
    sendWarp(0, 4'b0001, 8'h02, 16'h6100);
    check("R8 pair counted twice still busy", reqValid, 0);
    tick();
    check("R8 pair still busy", reqValid, 0);
    respond(1, 2'd2);
    check("R8 pair free after second release", reqValid, 1);
    collect(0, 4'b0001, 8'h02, 16'h6100);
    respond(1, 2'd2);

    // R4: strict threshold
    thresh = 6'd2;
    sendWarp(1, 4'b0000, 8'h08, 16'h8000);
    check("R4 admitted below limit", reqValid, 1);
    collect(1, 4'b0000, 8'h08, 16'h8000);
    sendWarp(0, 4'b0001, 8'h01, 16'h8100);
    check("R4 count equal to limit blocks", reqValid, 0);
    tick();
    check("R4 still blocked", reqValid, 0);
    respond(0, 2'd0);
    check("R4 admitted after count drops", reqValid, 1);
    collect(0, 4'b0001, 8'h01, 16'h8100);
    respond(0, 2'd2);
    respond(1, 2'd1);
    thresh = 6'd0;
    sendWarp(0, 4'b0000, 8'h00, 16'h8200);
    check("R4 zero limit blocks", reqValid, 0);
    tick(); tick();
    check("R4 zero limit still blocks", reqValid, 0);
    thresh = 6'd1;
    #1;
    check("R5 re-evaluated when limit rises", reqValid, 1);
    collect(0, 4'b0000, 8'h00, 16'h8200);
    respond(0, 2'd0);

    // R10: completion on idle counters does not wrap
    respond(1, 2'd0);
    sendWarp(0, 4'b0001, 8'h00, 16'h9000);
    check("R10 counters held at zero", reqValid, 1);
    collect(0, 4'b0001, 8'h00, 16'h9000);
    respond(1, 2'd0);

    // R7/R2: output backpressure
    thresh = 6'd63;
    reqReady = 1'b0;
    sendWarp(2, 4'b0111, 8'h24, 16'h5000);
    check("R7 first slot offered", reqAddr, 16'h5000);
    tick(); tick();
    check("R7 held under stall valid", reqValid, 1);
    check("R7 held under stall addr", reqAddr, 16'h5000);
    check("R2 closed under stall", warpReady, 0);
    reqReady = 1'b1;
    tick();
    check("R7 advanced after handshake", reqAddr, 16'h5001);
    reqReady = 1'b0;
    tick();
    check("R7 second slot held", reqAddr, 16'h5001);
    reqReady = 1'b1;
    tick();
    check("R7 last slot offered", reqAddr, 16'h5002);
    check("R2 closed until last handshake", warpReady, 0);
    tick();
    check("R2 open after last handshake", warpReady, 1);
    check("R7 nothing after last", reqValid, 0);
    respondAll(2, 4'b0111, 8'h24);

    // R9: admission and completion in the same cycle
    thresh = 6'd3;
    sendWarp(0, 4'b0000, 8'h03, 16'h7000);
    collect(0, 4'b0000, 8'h03, 16'h7000);
    reqReady = 1'b0;
    sendWarp(1, 4'b0011, 8'h04, 16'h7100);
    rspValid = 1'b1;
    rspMc = 1'b0;
    rspBank = 2'd3;
    check("R9 admit alongside completion", reqValid, 1);
    tick();
    rspValid = 1'b0;
    reqReady = 1'b1;
    collect(1, 4'b0011, 8'h04, 16'h7100);
    sendWarp(0, 4'b0001, 8'h02, 16'h7200);
    check("R9 both updates applied (count 2 < 3)", reqValid, 1);
    collect(0, 4'b0001, 8'h02, 16'h7200);
    sendWarp(0, 4'b0001, 8'h03, 16'h7300);
    check("R9 count reached 3 blocks", reqValid, 0);
    tick();
    respond(1, 2'd0);
    check("R9 release reopens", reqValid, 1);
    collect(0, 4'b0001, 8'h03, 16'h7300);
    respond(1, 2'd1);
    respond(1, 2'd2);
    respond(1, 2'd3);
    thresh = 6'd63;

    // R1: reset in the middle of activity
    sendWarp(0, 4'b0000, 8'h00, 16'hA000);
    collect(0, 4'b0000, 8'h00, 16'hA000);
    sendWarp(0, 4'b0000, 8'h00, 16'hA100);
    check("R1 pre-reset warp blocked", reqValid, 0);
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    check("R1 buffer emptied by reset", warpReady, 1);
    check("R1 no request after reset", reqValid, 0);
    sendWarp(0, 4'b0000, 8'h00, 16'hA200);
    check("R1 counters cleared by reset", reqValid, 1);
    collect(0, 4'b0000, 8'h00, 16'hA200);
    respond(0, 2'd0);

    tick();
    finishRun();
  end

endmodule